// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This block turns two IEEE-754 single-precision numbers into two 32-bit two's-complement integers at the same time. It reads only the low 64 bits of a 128-bit source operand. Bits 31:0 form lane 0 and bits 63:32 form lane 1. It writes a 64-bit result in which each integer sits in the same lane position as its source. A 2-bit rounding input picks the rounding used when a lane has a fractional part. Any lane that cannot be represented is given the fixed indefinite integer 8000_0000h.

Two summary flags report on the whole operation. The invalid flag is set when any lane was NaN, infinite or out of range. The inexact flag is set when any valid lane lost fraction bits. The conversion is combinational. A parameter adds one output register stage, and that stage is present by default.

Top module: `pf2i_top`

## Requirements
- R1: Result bits 31:0 come from source bits 31:0, and result bits 63:32 come from source bits 63:32. Source bits 127:64 have no effect on any output.
- R2: A finite input that is already an integer in the range -2^31 to 2^31-1 converts exactly to its two's-complement value, and no flag is set.
- R3: A lane with a nonzero fraction is rounded by roundMode. The encodings are: 00 to nearest, with ties to even; 01 toward negative infinity; 10 toward positive infinity; 11 toward zero.
- R4: A NaN of either kind, or an infinity of either sign, gives 8000_0000h in that lane and sets flagInvalid.
- R5: A rounded value above 2^31-1 or below -2^31 gives 8000_0000h in that lane and sets flagInvalid. An input of exactly -2^31 gives 8000_0000h with neither flag set.
- R6: flagInvalid is the OR of the per-lane invalid conditions. Whenever it is set, at least one lane of the result holds 8000_0000h.
- R7: flagInexact is set when any lane that is not invalid dropped nonzero fraction bits. Invalid lanes do not contribute to it.
- R8: Zeros and denormals convert to 0. The exceptions are a positive denormal rounded toward positive infinity, which gives +1, and a negative denormal rounded toward negative infinity, which gives -1.
- R9: With the default output register, the outputs follow the inputs one clock later. An active-low reset clears the result and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcOperand | input | 128 | Source operand; only bits 63:0 are used |
| roundMode | input | 2 | Rounding selection (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| result | output | 64 | Two packed 32-bit signed integers |
| flagInvalid | output | 1 | Some lane was NaN, infinite or out of range |
| flagInexact | output | 1 | Some valid lane discarded fraction bits |

## Verification
The bench sweeps every exponent, with several mantissa patterns, both signs and all four rounding modes. It compares each lane and both flags against a rounding model built on real numbers. The model is exercised most at the values 2^31 and -2^31, at halfway ties and at denormals. An off-by-one in the overflow limit would either reject -2^31 or accept +2^31. A wrong tie rule would turn 2.5 into 3. Treating the sign backwards in the directed modes would round -2.5 the wrong way. Mishandling denormals would leave tiny values at 0 when rounding up should give +1. A lane mix-up, or a leak from the ignored upper source bits, shows up because the bench uses distinct data in each lane.

// File: rtl/pf2i_pkg.sv
package pf2i_pkg;

  // Encoding of the rounding-control input.
  typedef enum logic [1:0] {
    RC_NEAREST = 2'b00,
    RC_DOWN    = 2'b01,
    RC_UP      = 2'b10,
    RC_ZERO    = 2'b11
  } roundSel_e;

  // One-hot strobes from the control module to every lane.
  typedef struct packed {
    logic nearest;
    logic down;
    logic up;
    logic zero;
  } roundStrobe_t;

endpackage

// File: rtl/pf2i_ctrl.sv
module pf2i_ctrl
  import pf2i_pkg::*;
(
  input  logic [1:0]   roundMode,
  output roundStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    case (roundSel_e'(roundMode))
      RC_NEAREST: strobe.nearest = 1'b1;
      RC_DOWN:    strobe.down    = 1'b1;
      RC_UP:      strobe.up      = 1'b1;
      RC_ZERO:    strobe.zero    = 1'b1;
      default:    strobe.zero    = 1'b1;
    endcase
  end

endmodule

// File: rtl/pf2i_lane.sv
module pf2i_lane
  import pf2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] fpIn,
  input  roundStrobe_t         strobe,
  output logic [INT_W-1:0]     intOut,
  output logic                 laneInvalid,
  output logic                 laneInexact
);

  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int FRAC_W = MAN_W + 3;
  localparam int EXT_W  = SIG_W + FRAC_W;
  localparam int E_W    = EXP_W + 2;
  localparam int MAG_W  = INT_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int ZERO_E = BIAS + MAN_W;      // exponent where the ulp is 1
  localparam int OVF_E  = BIAS + INT_W - 1;  // exponent where |x| >= 2^(INT_W-1)

  localparam logic [E_W-1:0]   ZERO_EV = E_W'(ZERO_E);
  localparam logic [E_W-1:0]   OVF_EV  = E_W'(OVF_E);
  localparam logic [E_W-1:0]   FRAC_V  = E_W'(FRAC_W);
  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'((64'd1 << (INT_W - 1)) - 64'd1);
  localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(64'd1 << (INT_W - 1));
  localparam logic [INT_W-1:0] INDEF   = {1'b1, {(INT_W-1){1'b0}}};

  logic             signBit;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic [SIG_W-1:0] sig;
  logic [E_W-1:0]   effExp;
  logic [E_W-1:0]   leftAmt;
  logic [E_W-1:0]   rightAmt;
  logic             isSpecial;
  logic             bigPath;
  logic             hugeExp;
  logic [EXT_W-1:0] ext;
  logic [SIG_W-1:0] intPart;
  logic             guardBit;
  logic             stickyBit;
  logic             roundInc;
  logic [MAG_W-1:0] mag;
  logic             rangeErr;

  // Field split and alignment.
  always_comb begin
    signBit   = fpIn[FP_W-1];
    expF      = fpIn[FP_W-2:MAN_W];
    manF      = fpIn[MAN_W-1:0];
    sig       = {|expF, manF};
    effExp    = (expF == '0) ? E_W'(1) : E_W'(expF);
    isSpecial = &expF;
    bigPath   = effExp >= ZERO_EV;
    hugeExp   = effExp >= OVF_EV;
    leftAmt   = effExp - ZERO_EV;
    rightAmt  = ZERO_EV - effExp;
    ext       = {sig, {FRAC_W{1'b0}}} >> rightAmt;
  end

  // Integer part, guard and sticky for values with a fractional part.
  always_comb begin
    intPart   = '0;
    guardBit  = 1'b0;
    stickyBit = 1'b0;
    if (!bigPath) begin
      if (rightAmt <= FRAC_V) begin
        intPart   = ext[EXT_W-1:FRAC_W];
        guardBit  = ext[FRAC_W-1];
        stickyBit = |ext[FRAC_W-2:0];
      end else begin
        stickyBit = |sig;
      end
    end
  end

  // Rounding increment chosen by the strobes.
  always_comb begin
    roundInc = (strobe.nearest & guardBit & (stickyBit | intPart[0]))
             | (strobe.down & signBit & (guardBit | stickyBit))
             | (strobe.up & ~signBit & (guardBit | stickyBit));
  end

  // Magnitude, range test and final encoding.
  always_comb begin
    if (bigPath) mag = MAG_W'(sig) << leftAmt;
    else         mag = MAG_W'(intPart) + MAG_W'(roundInc);

    if (hugeExp)
      rangeErr = !(signBit && (effExp == OVF_EV) && (manF == '0));
    else
      rangeErr = mag > (signBit ? NEG_LIM : POS_LIM);

    laneInvalid = isSpecial | rangeErr;
    laneInexact = ~laneInvalid & (guardBit | stickyBit);

    if (laneInvalid)  intOut = INDEF;
    else if (signBit) intOut = -mag[INT_W-1:0];
    else              intOut = mag[INT_W-1:0];
  end

endmodule

// File: rtl/pf2i_datapath.sv
module pf2i_datapath
  import pf2i_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int INT_W   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] srcLanes,
  input  roundStrobe_t                   strobe,
  output logic [LANES*INT_W-1:0]         result,
  output logic                           flagInvalid,
  output logic                           flagInexact
);

  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic [LANES*INT_W-1:0] laneRes;
  logic [LANES-1:0]       laneInv;
  logic [LANES-1:0]       laneInx;
  logic                   anyInv;
  logic                   anyInx;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    pf2i_lane #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W),
      .INT_W(INT_W)
    ) uLane (
      .fpIn       (srcLanes[g*FP_W +: FP_W]),
      .strobe     (strobe),
      .intOut     (laneRes[g*INT_W +: INT_W]),
      .laneInvalid(laneInv[g]),
      .laneInexact(laneInx[g])
    );
  end

  assign anyInv = |laneInv;
  assign anyInx = |laneInx;

  if (OUT_REG) begin : gReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result      <= '0;
        flagInvalid <= 1'b0;
        flagInexact <= 1'b0;
      end else begin
        result      <= laneRes;
        flagInvalid <= anyInv;
        flagInexact <= anyInx;
      end
    end
  end else begin : gComb
    assign result      = laneRes;
    assign flagInvalid = anyInv;
    assign flagInexact = anyInx;
  end

endmodule

// File: rtl/pf2i_top.sv
module pf2i_top
  import pf2i_pkg::*;
#(
  parameter int SRC_W   = 128,
  parameter int LANES   = 2,
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int INT_W   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_W-1:0]       srcOperand,
  input  logic [1:0]             roundMode,
  output logic [LANES*INT_W-1:0] result,
  output logic                   flagInvalid,
  output logic                   flagInexact
);

  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int USED_W = LANES * FP_W;

  roundStrobe_t strobe;

  pf2i_ctrl uCtrl (
    .roundMode(roundMode),
    .strobe   (strobe)
  );

  pf2i_datapath #(
    .LANES  (LANES),
    .EXP_W  (EXP_W),
    .MAN_W  (MAN_W),
    .INT_W  (INT_W),
    .OUT_REG(OUT_REG)
  ) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcLanes   (srcOperand[USED_W-1:0]),
    .strobe     (strobe),
    .result     (result),
    .flagInvalid(flagInvalid),
    .flagInexact(flagInexact)
  );

  if (SRC_W > USED_W) begin : gHigh
    logic unusedHighBits;
    assign unusedHighBits = ^srcOperand[SRC_W-1:USED_W];
  end

endmodule

// File: rtl/pf2i_checker.sv
module pf2i_checker #(
  parameter int SRC_W   = 128,
  parameter int LANES   = 2,
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int INT_W   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SRC_W-1:0]       srcOperand,
  input logic [1:0]             roundMode,
  input logic [LANES*INT_W-1:0] result,
  input logic                   flagInvalid,
  input logic                   flagInexact
);

  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [FP_W-1:0]  seenSrc;
  logic [1:0]       seenRc;
  logic             armed;
  logic [EXP_W-1:0] seenExp;
  logic             seenSign;
  logic             seenNonZero;
  logic [INT_W-1:0] lane0;
  logic             anyIndef;
  logic             unusedChkBits;

  assign unusedChkBits = ^srcOperand[SRC_W-1:FP_W] ^ flagInexact;

  if (OUT_REG) begin : gSeen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seenSrc <= '0;
        seenRc  <= '0;
        armed   <= 1'b0;
      end else begin
        seenSrc <= srcOperand[FP_W-1:0];
        seenRc  <= roundMode;
        armed   <= 1'b1;
      end
    end
  end else begin : gSeenComb
    assign seenSrc = srcOperand[FP_W-1:0];
    assign seenRc  = roundMode;
    assign armed   = rst_n;
  end

  always_comb begin
    seenExp     = seenSrc[FP_W-2:MAN_W];
    seenSign    = seenSrc[FP_W-1];
    seenNonZero = |seenSrc[FP_W-2:0];
    lane0       = result[INT_W-1:0];
    anyIndef    = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (result[i*INT_W +: INT_W] == INDEF) anyIndef = 1'b1;
  end

  assert_nan_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (&seenExp)) |-> (lane0 == INDEF && flagInvalid));

  assert_invalid_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flagInvalid |-> anyIndef);

  assert_trunc_small_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && seenRc == 2'b11 && seenExp < EXP_W'(BIAS)) |-> (lane0 == '0));

  assert_up_small_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && seenRc == 2'b10 && !seenSign && seenNonZero && seenExp < EXP_W'(BIAS))
      |-> (lane0 == INT_W'(1)));

  assert_zero_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !seenNonZero) |-> (lane0 == '0));

  assert_down_tiny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && seenRc == 2'b01 && seenSign && seenNonZero && seenExp < EXP_W'(BIAS))
      |-> (lane0 == '1));

endmodule

bind pf2i_top pf2i_checker #(
  .SRC_W  (SRC_W),
  .LANES  (LANES),
  .EXP_W  (EXP_W),
  .MAN_W  (MAN_W),
  .INT_W  (INT_W),
  .OUT_REG(OUT_REG)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srcOperand (srcOperand),
  .roundMode  (roundMode),
  .result     (result),
  .flagInvalid(flagInvalid),
  .flagInexact(flagInexact)
);

// File: tb/sim_pf2i_top.sv
`timescale 1ns/1ps
module sim_pf2i_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] src;
  logic [1:0]   rm;
  logic [63:0]  result;
  logic         flagInvalid;
  logic         flagInexact;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pf2i_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcOperand (src),
    .roundMode  (rm),
    .result     (result),
    .flagInvalid(flagInvalid),
    .flagInexact(flagInexact)
  );

  // Real-number reference: returns {invalid, inexact, value}.
  function automatic logic [33:0] refLane(input logic [31:0] b, input logic [1:0] rc);
    int  e;
    real v, r, fl, d;
    e = int'(b[30:23]);
    if (e == 255) return {1'b1, 1'b0, 32'h8000_0000};
    if (e == 0) v = real'(b[22:0]) * (2.0 ** (-149));
    else        v = (real'(b[22:0]) + 8388608.0) * (2.0 ** (e - 150));
    if (b[31]) v = -v;
    case (rc)
      2'b00: begin
        fl = $floor(v);
        d  = v - fl;
        if (d > 0.5)      r = fl + 1.0;
        else if (d < 0.5) r = fl;
        else              r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'b01:   r = $floor(v);
      2'b10:   r = $ceil(v);
      default: r = (v < 0.0) ? $ceil(v) : $floor(v);
    endcase
    if (r < -2147483648.0 || r > 2147483647.0) return {1'b1, 1'b0, 32'h8000_0000};
    return {1'b0, (r != v), 32'(longint'(r))};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] l0, input logic [31:0] l1,
                       input logic [63:0] hi, input logic [1:0] rc);
    @(negedge clk);
    src = {hi, l1, l0};
    rm  = rc;
    @(posedge clk);
    #2;
  endtask

  task automatic expectOne(input string tag, input logic [31:0] l0, input logic [1:0] rc,
                           input logic [31:0] expRes, input logic expInv, input logic expInx);
    apply(l0, 32'h0, 64'h0, rc);
    check(tag, "lane0", {32'h0, result[31:0]}, {32'h0, expRes});
    check(tag, "flags", {62'h0, flagInvalid, flagInexact}, {62'h0, expInv, expInx});
  endtask

  function automatic logic [22:0] pat(input int k);
    case (k)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7FFFFF;
      4: return 23'h200000;
      5: return 23'h600000;
      6: return 23'h000003;
      default: return 23'h3FFFFF;
    endcase
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [63:0] firstRes;
    rst_n = 1'b0;
    src   = {64'h0, 32'h7FC0_0000, 32'h7FC0_0000};
    rm    = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    // R9: reset holds result and flags at zero even with NaN inputs
    check("R9", "reset result", result, 64'h0);
    check("R9", "reset flags", {62'h0, flagInvalid, flagInexact}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: exact integers
    expectOne("R2", 32'h42F6_0000, 2'b00, 32'h0000_007B, 1'b0, 1'b0);
    expectOne("R2", 32'hC2F6_0000, 2'b11, 32'hFFFF_FF85, 1'b0, 1'b0);
    // R3: rounding of 2.5, 3.5 and -2.5 in each mode
    expectOne("R3", 32'h4020_0000, 2'b00, 32'h0000_0002, 1'b0, 1'b1);
    expectOne("R3", 32'h4060_0000, 2'b00, 32'h0000_0004, 1'b0, 1'b1);
    expectOne("R3", 32'h4020_0000, 2'b10, 32'h0000_0003, 1'b0, 1'b1);
    expectOne("R3", 32'h4020_0000, 2'b01, 32'h0000_0002, 1'b0, 1'b1);
    expectOne("R3", 32'hC020_0000, 2'b00, 32'hFFFF_FFFE, 1'b0, 1'b1);
    expectOne("R3", 32'hC020_0000, 2'b01, 32'hFFFF_FFFD, 1'b0, 1'b1);
    expectOne("R3", 32'hC020_0000, 2'b10, 32'hFFFF_FFFE, 1'b0, 1'b1);
    expectOne("R3", 32'hC020_0000, 2'b11, 32'hFFFF_FFFE, 1'b0, 1'b1);
    // R4: NaNs and infinities
    expectOne("R4", 32'h7FC0_0000, 2'b00, 32'h8000_0000, 1'b1, 1'b0);
    expectOne("R4", 32'h7F80_0001, 2'b01, 32'h8000_0000, 1'b1, 1'b0);
    expectOne("R4", 32'hFF80_0000, 2'b10, 32'h8000_0000, 1'b1, 1'b0);
    // R5: range boundaries
    expectOne("R5", 32'h4F00_0000, 2'b00, 32'h8000_0000, 1'b1, 1'b0);
    expectOne("R5", 32'hCF00_0000, 2'b00, 32'h8000_0000, 1'b0, 1'b0);
    expectOne("R5", 32'h4EFF_FFFF, 2'b10, 32'h7FFF_FF80, 1'b0, 1'b0);
    expectOne("R5", 32'hCF00_0001, 2'b11, 32'h8000_0000, 1'b1, 1'b0);
    // R8: zeros and denormals
    expectOne("R8", 32'h8000_0000, 2'b01, 32'h0000_0000, 1'b0, 1'b0);
    expectOne("R8", 32'h0000_0001, 2'b00, 32'h0000_0000, 1'b0, 1'b1);
    expectOne("R8", 32'h0000_0001, 2'b10, 32'h0000_0001, 1'b0, 1'b1);
    expectOne("R8", 32'h8000_0001, 2'b01, 32'hFFFF_FFFF, 1'b0, 1'b1);

    // R6: only lane 1 invalid still raises the flag
    apply(32'h42F6_0000, 32'h7F80_0000, 64'h0, 2'b00);
    check("R6", "lane1 invalid", {result, 63'h0, flagInvalid}, {32'h8000_0000, 32'h7B, 63'h0, 1'b1});
    // R7: invalid lane does not give inexact; the other lane can
    apply(32'h7FC0_0000, 32'h4020_0000, 64'h0, 2'b00);
    check("R7", "valid lane inexact", {62'h0, flagInvalid, flagInexact}, {62'h0, 1'b1, 1'b1});
    apply(32'h7FC0_0000, 32'h42F6_0000, 64'h0, 2'b00);
    check("R7", "invalid lane no inexact", {62'h0, flagInvalid, flagInexact}, {62'h0, 1'b1, 1'b0});

    // R1: lane placement and ignored upper source bits
    apply(32'h4020_0000, 32'hC2F6_0000, 64'h0, 2'b00);
    firstRes = result;
    check("R1", "lane order", result, {32'hFFFF_FF85, 32'h0000_0002});
    apply(32'h4020_0000, 32'hC2F6_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00);
    check("R1", "upper bits ignored", result, firstRes);

    // R9: one-clock latency
    @(negedge clk);
    src = {64'h0, 32'h0, 32'h42F6_0000};
    #1;
    check("R9", "holds before edge", result, firstRes);
    @(posedge clk);
    #2;
    check("R9", "updates after edge", result, 64'h0000_0000_0000_007B);

    // Sweep over exponents, mantissas, signs and rounding modes
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 8; k++) begin
        for (int s = 0; s < 2; s++) begin
          for (int rc = 0; rc < 4; rc++) begin
            logic [31:0] l0, l1;
            logic [33:0] r0, r1;
            string t0, t1;
            l0 = {1'(s), 8'(e), pat(k)};
            l1 = {1'(1 - s), 8'(e * 3 + k), pat((k + 3) % 8)};
            r0 = refLane(l0, 2'(rc));
            r1 = refLane(l1, 2'(rc));
            apply(l0, l1, {32'hA5A5_0000 ^ 32'(e), 32'(k)}, 2'(rc));
            t0 = r0[33] ? "R4/R5" : (e == 0 ? "R8" : (r0[32] ? "R3" : "R2"));
            t1 = r1[33] ? "R4/R5" : (r1[32] ? "R3" : "R2");
            check(t0, "sweep lane0", {32'h0, result[31:0]}, {32'h0, r0[31:0]});
            check(t1, "sweep lane1", {32'h0, result[63:32]}, {32'h0, r1[31:0]});
            check("R6", "sweep invalid", {63'h0, flagInvalid}, {63'h0, r0[33] | r1[33]});
            check("R7", "sweep inexact", {63'h0, flagInexact}, {63'h0, r0[32] | r1[32]});
          end
        end
      end
    end

    finishRun();
  end

endmodule